// File: doc/BRIEF.md
# Bank Command Scheduler with Restore Priority

This block orders memory commands for a single bank. Three producers feed it through valid/ready push ports: host reads, host writes and restore requests. A restore request asks for a cell range to be refreshed against read disturbance. The block keeps each source in its own first-in first-out queue and presents one command at a time on an issue port. The issue port carries a command code and an address, and a command leaves when `iss_valid` and `iss_ready` are both high.

Reads outrank restores, and restores outrank writes. A restore is carried out as two issued commands on the same address: first a read that fetches the old contents, then a write that puts them back. Nothing may come between these two. Writes normally wait. When the write queue fills, it takes precedence until its occupancy drops to a low watermark. A restore whose address already sits in the write queue is discarded at the push port, because that pending write will rewrite the cells anyway.

Top module: `bank_cmd_sched`

## Requirements
- R1: After reset, `iss_valid` is low and all three push-ready outputs are high.
- R2: Commands taken from any one queue are issued in the order they were pushed.
- R3: Outside a write drain and outside a restore pair, a pending read is issued before any restore or write.
- R4: Outside a write drain, a pending restore is issued before any write.
- R5: A restore is issued as code 2 (pre-write read) and then code 3 (rewrite) on the same address. The rewrite is offered in the very next cycle after the pre-write read leaves, and it stays offered with no other command between the two, however long `iss_ready` is held low.
- R6: A restore pushed while a write to the same address is queued is accepted and discarded, and no restore commands are issued for it.
- R7: A restore pushed in the same cycle that a matching write leaves on the issue port is also discarded.
- R8: When the write queue holds `WR_DEPTH` entries, writes are issued ahead of reads and restores. This continues until the queue holds `WR_LOW` entries (48 by default), and then the normal priority returns.
- R9: A push-ready output is low exactly while its queue is full. The restore queue holds `RS_DEPTH` entries (8 by default), and the read and write queues hold 64 each.
- R10: The issue codes on `iss_cmd` are 0 for a read, 1 for a write, 2 for a restore pre-write read and 3 for a restore rewrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read queue can accept |
| rd_addr | input | AW | Read address |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write queue can accept |
| wr_addr | input | AW | Write address |
| rs_valid | input | 1 | Restore request present |
| rs_ready | output | 1 | Restore queue can accept |
| rs_addr | input | AW | Restore address |
| iss_valid | output | 1 | A command is offered |
| iss_ready | input | 1 | Memory side accepts the offered command |
| iss_cmd | output | 2 | Command code (see R10) |
| iss_addr | output | AW | Command address |

## Verification
The checker watches the priority relations on every cycle. Outside a drain, no write leaves while a read or restore waits, and no restore leaves ahead of a read. During a drain, every offer is a write or a pending rewrite. After every pre-write read, the matching rewrite follows and holds while stalled. The checker also confirms that the restore occupancy never exceeds its depth. Some behaviours can only be shown by the bench's scenarios, because they concern which commands never appear: the exact order of mixed traffic, the point where a drain ends, and the two merge cases (a queued write, and a write leaving in the same cycle). The bench's scoreboard compares the full issue stream and flags any extra command.

// File: rtl/bank_sched_pkg.sv
package bank_sched_pkg;

    typedef enum logic [1:0] {
        CMD_RD  = 2'd0,
        CMD_WR  = 2'd1,
        CMD_RRD = 2'd2,
        CMD_RWR = 2'd3
    } cmd_e;

    typedef enum logic {
        PH_FREE    = 1'b0,
        PH_REWRITE = 1'b1
    } phase_e;

    function automatic logic is_restore(cmd_e c);
        return (c == CMD_RRD) || (c == CMD_RWR);
    endfunction

endpackage

// File: rtl/bank_sched_fifo.sv
module bank_sched_fifo #(
    parameter int DEPTH  = 8,
    parameter int AW     = 25,
    parameter bit SEARCH = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push,
    input  logic [AW-1:0]               push_addr,
    input  logic                        pop,
    output logic [AW-1:0]               head_addr,
    output logic                        empty,
    output logic                        full,
    output logic [$clog2(DEPTH):0]      count,
    input  logic [AW-1:0]               look_addr,
    output logic                        look_hit
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [AW-1:0] slots [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) slots[wp] <= push_addr;
    end

    assign head_addr = slots[rp];
    assign empty     = (cnt == '0);
    assign full      = (cnt == CW'(DEPTH));
    assign count     = cnt;

    generate
        if (SEARCH) begin : g_search
            logic [DEPTH-1:0] hits;
            for (genvar i = 0; i < DEPTH; i++) begin : g_slot
                logic [PW-1:0] off;
                assign off     = PW'(i) - rp;
                assign hits[i] = ({1'b0, off} < cnt) && (slots[i] == look_addr);
            end
            assign look_hit = |hits;
        end else begin : g_nosearch
            logic unused_look;
            assign unused_look = ^look_addr;
            assign look_hit    = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/bank_sched_drain.sv
module bank_sched_drain #(
    parameter int DEPTH = 64,
    parameter int LOW   = 48
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [$clog2(DEPTH):0] count,
    output logic                   drain
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic latched;

    always_ff @(posedge clk) begin
        if (rst)                          latched <= 1'b0;
        else if (count == CW'(DEPTH))     latched <= 1'b1;
        else if (count <= CW'(LOW))       latched <= 1'b0;
    end

    assign drain = (count == CW'(DEPTH)) || (latched && (count > CW'(LOW)));

endmodule

// File: rtl/bank_sched_arb.sv
module bank_sched_arb
    import bank_sched_pkg::*;
#(
    parameter int AW = 25
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_empty,
    input  logic          rs_empty,
    input  logic          wr_empty,
    input  logic          drain,
    input  logic [AW-1:0] rd_head,
    input  logic [AW-1:0] rs_head,
    input  logic [AW-1:0] wr_head,
    input  logic          iss_ready,
    output logic          iss_valid,
    output cmd_e          iss_cmd,
    output logic [AW-1:0] iss_addr,
    output logic          rd_pop,
    output logic          rs_pop,
    output logic          wr_pop
);
    phase_e        phase;
    logic [AW-1:0] hold_addr;
    logic          fire;

    always_comb begin
        iss_valid = 1'b0;
        iss_cmd   = CMD_RD;
        iss_addr  = rd_head;
        if (phase == PH_REWRITE) begin
            iss_valid = 1'b1;
            iss_cmd   = CMD_RWR;
            iss_addr  = hold_addr;
        end else if (drain && !wr_empty) begin
            iss_valid = 1'b1;
            iss_cmd   = CMD_WR;
            iss_addr  = wr_head;
        end else if (!rd_empty) begin
            iss_valid = 1'b1;
            iss_cmd   = CMD_RD;
            iss_addr  = rd_head;
        end else if (!rs_empty) begin
            iss_valid = 1'b1;
            iss_cmd   = CMD_RRD;
            iss_addr  = rs_head;
        end else if (!wr_empty) begin
            iss_valid = 1'b1;
            iss_cmd   = CMD_WR;
            iss_addr  = wr_head;
        end
    end

    assign fire   = iss_valid && iss_ready;
    assign rd_pop = fire && (iss_cmd == CMD_RD);
    assign wr_pop = fire && (iss_cmd == CMD_WR);
    assign rs_pop = fire && (iss_cmd == CMD_RRD);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_FREE;
            hold_addr <= '0;
        end else if (fire && iss_cmd == CMD_RRD) begin
            phase     <= PH_REWRITE;
            hold_addr <= rs_head;
        end else if (fire && iss_cmd == CMD_RWR) begin
            phase     <= PH_FREE;
        end
    end

endmodule

// File: rtl/bank_cmd_sched.sv
module bank_cmd_sched
    import bank_sched_pkg::*;
#(
    parameter int AW       = 25,
    parameter int RD_DEPTH = 64,
    parameter int WR_DEPTH = 64,
    parameter int WR_LOW   = 48,
    parameter int RS_DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic          rs_valid,
    output logic          rs_ready,
    input  logic [AW-1:0] rs_addr,
    output logic          iss_valid,
    input  logic          iss_ready,
    output logic [1:0]    iss_cmd,
    output logic [AW-1:0] iss_addr
);
    localparam int RDCW = $clog2(RD_DEPTH) + 1;
    localparam int WRCW = $clog2(WR_DEPTH) + 1;
    localparam int RSCW = $clog2(RS_DEPTH) + 1;

    logic            rd_empty, rd_full, rd_pop, rd_hit;
    logic            wr_empty, wr_full, wr_pop, wr_hit;
    logic            rs_empty, rs_full, rs_pop, rs_hit, rs_push;
    logic [AW-1:0]   rd_head, wr_head, rs_head;
    logic [RDCW-1:0] rd_cnt;
    logic [WRCW-1:0] wr_cnt;
    logic [RSCW-1:0] rs_cnt;
    logic            drain_act;
    cmd_e            cmd_sel;

    assign rd_ready = !rd_full;
    assign wr_ready = !wr_full;
    assign rs_ready = !rs_full;

    // a restore whose address is still held by the write queue (even one
    // leaving this cycle) is taken from the port but never stored
    assign rs_push = rs_valid && rs_ready && !wr_hit;

    bank_sched_fifo #(.DEPTH(RD_DEPTH), .AW(AW), .SEARCH(1'b0)) u_rdq (
        .clk(clk), .rst(rst),
        .push(rd_valid && rd_ready), .push_addr(rd_addr),
        .pop(rd_pop), .head_addr(rd_head),
        .empty(rd_empty), .full(rd_full), .count(rd_cnt),
        .look_addr(rd_addr), .look_hit(rd_hit)
    );

    bank_sched_fifo #(.DEPTH(WR_DEPTH), .AW(AW), .SEARCH(1'b1)) u_wrq (
        .clk(clk), .rst(rst),
        .push(wr_valid && wr_ready), .push_addr(wr_addr),
        .pop(wr_pop), .head_addr(wr_head),
        .empty(wr_empty), .full(wr_full), .count(wr_cnt),
        .look_addr(rs_addr), .look_hit(wr_hit)
    );

    bank_sched_fifo #(.DEPTH(RS_DEPTH), .AW(AW), .SEARCH(1'b0)) u_rsq (
        .clk(clk), .rst(rst),
        .push(rs_push), .push_addr(rs_addr),
        .pop(rs_pop), .head_addr(rs_head),
        .empty(rs_empty), .full(rs_full), .count(rs_cnt),
        .look_addr(rs_addr), .look_hit(rs_hit)
    );

    bank_sched_drain #(.DEPTH(WR_DEPTH), .LOW(WR_LOW)) u_drain (
        .clk(clk), .rst(rst), .count(wr_cnt), .drain(drain_act)
    );

    bank_sched_arb #(.AW(AW)) u_arb (
        .clk(clk), .rst(rst),
        .rd_empty(rd_empty), .rs_empty(rs_empty), .wr_empty(wr_empty),
        .drain(drain_act),
        .rd_head(rd_head), .rs_head(rs_head), .wr_head(wr_head),
        .iss_ready(iss_ready),
        .iss_valid(iss_valid), .iss_cmd(cmd_sel), .iss_addr(iss_addr),
        .rd_pop(rd_pop), .rs_pop(rs_pop), .wr_pop(wr_pop)
    );

    assign iss_cmd = cmd_sel;

    logic unused_sink;
    assign unused_sink = ^{rd_hit, rs_hit, rd_cnt};

endmodule

// File: rtl/bank_cmd_sched_chk.sv
module bank_cmd_sched_chk
    import bank_sched_pkg::*;
#(
    parameter int AW       = 25,
    parameter int WR_DEPTH = 64,
    parameter int WR_LOW   = 48,
    parameter int RS_DEPTH = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      iss_valid,
    input logic                      iss_ready,
    input logic [1:0]                iss_cmd,
    input logic [AW-1:0]             iss_addr,
    input logic                      rd_empty,
    input logic                      rs_empty,
    input logic [$clog2(WR_DEPTH):0] wr_cnt,
    input logic [$clog2(RS_DEPTH):0] rs_cnt,
    input logic                      drain_act,
    input logic                      rs_ready
);
    localparam int WRCW = $clog2(WR_DEPTH) + 1;
    localparam int RSCW = $clog2(RS_DEPTH) + 1;

    assert_pair_follow_R5: assert property (@(posedge clk) disable iff (rst)
        $past(iss_valid && iss_ready && iss_cmd == CMD_RRD) |->
            (iss_valid && iss_cmd == CMD_RWR && iss_addr == $past(iss_addr)));

    assert_pair_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready && iss_cmd == CMD_RWR) |=>
            (iss_valid && iss_cmd == CMD_RWR && $stable(iss_addr)));

    assert_read_first_R3: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_cmd == CMD_WR && !drain_act) |-> (rd_empty && rs_empty));

    assert_restore_over_write_R4: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_cmd == CMD_RRD) |-> (rd_empty && !drain_act));

    assert_drain_writes_R8: assert property (@(posedge clk) disable iff (rst)
        drain_act |-> (iss_valid && (iss_cmd == CMD_WR || iss_cmd == CMD_RWR)));

    assert_drain_stops_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_cnt <= WRCW'(WR_LOW)) |-> !drain_act);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (rs_cnt <= RSCW'(RS_DEPTH)) && ((rs_cnt == RSCW'(RS_DEPTH)) -> !rs_ready));

endmodule

bind bank_cmd_sched bank_cmd_sched_chk #(
    .AW(AW), .WR_DEPTH(WR_DEPTH), .WR_LOW(WR_LOW), .RS_DEPTH(RS_DEPTH)
) u_chk (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_cmd(iss_cmd), .iss_addr(iss_addr),
    .rd_empty(rd_empty), .rs_empty(rs_empty),
    .wr_cnt(wr_cnt), .rs_cnt(rs_cnt),
    .drain_act(drain_act), .rs_ready(rs_ready)
);

// File: tb/tb_bank_cmd_sched.sv
`timescale 1ns/100ps
module tb_bank_cmd_sched;
    localparam int AW = 25;
    localparam logic [1:0] C_RD = 2'd0, C_WR = 2'd1, C_RRD = 2'd2, C_RWR = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_valid = 1'b0, wr_valid = 1'b0, rs_valid = 1'b0, iss_ready = 1'b0;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0, rs_addr = '0;
    logic rd_ready, wr_ready, rs_ready, iss_valid;
    logic [1:0] iss_cmd;
    logic [AW-1:0] iss_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [AW+1:0] exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    bank_cmd_sched dut (
        .clk(clk), .rst(rst),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_addr(rs_addr),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_cmd(iss_cmd), .iss_addr(iss_addr)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic expect_cmd(logic [1:0] c, logic [AW-1:0] a, string req);
        exp_q.push_back({c, a});
        tag_q.push_back(req);
    endtask

    // monitor: a handshake seen at the falling edge completes at the next rise
    always @(negedge clk) begin
        if (!rst && iss_valid && iss_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected issue", {iss_cmd, iss_addr}, 0);
            end else begin
                logic [AW+1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({iss_cmd, iss_addr} == e, t, "issue stream", {iss_cmd, iss_addr}, e);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(int src, logic [AW-1:0] a);
        case (src)
            0: begin rd_valid = 1'b1; rd_addr = a; end
            1: begin wr_valid = 1'b1; wr_addr = a; end
            default: begin rs_valid = 1'b1; rs_addr = a; end
        endcase
        do @(negedge clk);
        while (!((src == 0) ? rd_ready : (src == 1) ? wr_ready : rs_ready));
        step();
        rd_valid = 1'b0; wr_valid = 1'b0; rs_valid = 1'b0;
    endtask

    task automatic wait_done(string req);
        int guard = 0;
        while (exp_q.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(exp_q.size() == 0, req, "pending expected", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        chk(iss_valid == 1'b0, req, "idle after stream", iss_valid, 0);
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(iss_valid == 1'b0, "R1", "iss_valid", iss_valid, 0);
        chk(rd_ready && wr_ready && rs_ready, "R1", "readies",
            {rd_ready, wr_ready, rs_ready}, 3'b111);
        step();

        // R2 R3 R4 R5 R10: mixed traffic loaded while the memory side stalls
        push(1, 25'h00D0); push(2, 25'h00C0); push(0, 25'h00A0);
        push(1, 25'h00E0); push(0, 25'h00B0);
        expect_cmd(C_RD,  25'h00A0, "R3");
        expect_cmd(C_RD,  25'h00B0, "R2");
        expect_cmd(C_RRD, 25'h00C0, "R4");
        expect_cmd(C_RWR, 25'h00C0, "R5");
        expect_cmd(C_WR,  25'h00D0, "R10");
        expect_cmd(C_WR,  25'h00E0, "R2");
        iss_ready = 1'b1;
        wait_done("R3");
        iss_ready = 1'b0;

        // R6: restore hitting a queued write disappears
        push(1, 25'h0111); push(2, 25'h0111); push(2, 25'h0222);
        expect_cmd(C_RRD, 25'h0222, "R6");
        expect_cmd(C_RWR, 25'h0222, "R6");
        expect_cmd(C_WR,  25'h0111, "R6");
        iss_ready = 1'b1;
        wait_done("R6");
        iss_ready = 1'b0;

        // R7: restore arriving as the matching write leaves
        push(1, 25'h0333);
        expect_cmd(C_WR, 25'h0333, "R7");
        iss_ready = 1'b1; rs_valid = 1'b1; rs_addr = 25'h0333;
        @(negedge clk);
        chk(rs_ready == 1'b1, "R7", "restore accepted", rs_ready, 1);
        step();
        rs_valid = 1'b0;
        wait_done("R7");
        iss_ready = 1'b0;

        // R5: rewrite stays offered through a stall while a read waits
        push(2, 25'h0444);
        expect_cmd(C_RRD, 25'h0444, "R5");
        expect_cmd(C_RWR, 25'h0444, "R5");
        expect_cmd(C_RD,  25'h0555, "R5");
        iss_ready = 1'b1;
        step();
        iss_ready = 1'b0; rd_valid = 1'b1; rd_addr = 25'h0555;
        step();
        rd_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(iss_valid && iss_cmd == C_RWR && iss_addr == 25'h0444, "R5",
                "rewrite held", {iss_valid, iss_cmd, iss_addr}, {1'b1, C_RWR, 25'h0444});
        end
        step();
        iss_ready = 1'b1;
        wait_done("R5");
        iss_ready = 1'b0;

        // R9: restore queue of 8 refuses a ninth entry
        for (int k = 0; k < 8; k++) begin
            push(2, 25'h1000 + AW'(k));
            expect_cmd(C_RRD, 25'h1000 + AW'(k), "R9");
            expect_cmd(C_RWR, 25'h1000 + AW'(k), "R9");
        end
        rs_valid = 1'b1; rs_addr = 25'h1FFF;
        @(negedge clk);
        chk(rs_ready == 1'b0, "R9", "restore ready when full", rs_ready, 0);
        step();
        rs_valid = 1'b0;
        iss_ready = 1'b1;
        wait_done("R9");
        iss_ready = 1'b0;

        // R8: full write queue drains 16 entries ahead of a read and a restore
        for (int k = 0; k < 64; k++) push(1, 25'h2000 + AW'(k));
        @(negedge clk);
        chk(wr_ready == 1'b0, "R9", "write ready when full", wr_ready, 0);
        chk(rd_ready == 1'b1, "R9", "read ready with write full", rd_ready, 1);
        step();
        push(0, 25'h3000); push(2, 25'h3100);
        for (int k = 0; k < 16; k++) expect_cmd(C_WR, 25'h2000 + AW'(k), "R8");
        expect_cmd(C_RD,  25'h3000, "R8");
        expect_cmd(C_RRD, 25'h3100, "R8");
        expect_cmd(C_RWR, 25'h3100, "R8");
        for (int k = 16; k < 64; k++) expect_cmd(C_WR, 25'h2000 + AW'(k), "R2");
        iss_ready = 1'b1;
        wait_done("R8");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule